// File: doc/BRIEF.md
# Packet Interrupt Delay Timers

This block holds back completion interrupts of a network controller so that several completed descriptors can be reported with one interrupt. Each direction, receive and transmit, has two timers. The packet timer starts again on every completion. The absolute timer starts at the first completion of a burst and bounds the total wait. When either timer runs out, the direction raises a one-cycle cause pulse toward the interrupt cause register. The receive pulse is the receive-timer cause. The transmit pulse is the descriptor-written cause.

Four delay inputs come from software-written registers. Each delay counts in units of `2**UNIT_LOG2` core clocks. With the default of 256 clocks at a 4 ns core period, one unit is 1024 ns. The completion inputs are single-cycle pulses from the descriptor engines. The `post_now` strobe comes from the interrupt controller when it raises an interrupt for any other reason. A pending timer then has no reason to keep waiting, so its cause is reported at once.

All pins are plain level or pulse signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure. A cause pulse is never held or queued.

Top module: `ditmr_top`

## Requirements
- R1: After reset both cause outputs are low, and a direction raises no cause before its first completion pulse.
- R2: With a nonzero packet delay P and a zero absolute delay, a completion sampled at clock edge E makes the cause output high for exactly the one cycle that follows edge E + P·2^UNIT_LOG2.
- R3: A completion that arrives while the packet timer is running restarts the packet timer with the full delay. The earlier expiry does not happen.
- R4: A completion arms the absolute timer only when both the packet delay and the absolute delay are nonzero. Once armed, the absolute timer expires A·2^UNIT_LOG2 cycles after the completion that armed it, where A is the absolute delay. Later completions neither restart nor extend it.
- R5: A completion with a zero packet delay never arms the absolute timer, whatever the absolute delay is.
- R6: A completion with a zero packet delay raises the cause in the cycle right after the edge that samples it.
- R7: When a delay input is zero at a clock edge, the matching timer stops without raising a cause. Setting the delay nonzero again later does not revive that timer.
- R8: When `post_now` is sampled while either timer of a direction is running, that direction raises its cause in the next cycle and both of its timers are cancelled.
- R9: `post_now` with no timer running raises no cause.
- R10: Any cause of a direction, whether it comes from a packet timer expiry, an absolute timer expiry or a flush, cancels both timers of that direction.
- R11: The transmit direction follows the same rules as receive through its own inputs and `tx_cause`. The two directions do not affect each other, except that both share `post_now`.
- R12: A completion sampled at the same edge as a flush or an expiry re-arms the timers after the cancellation, so the new timers run from that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_pkt_delay | input | DLY_W | Receive packet delay, in timer units (0 = off) |
| rx_abs_delay | input | DLY_W | Receive absolute delay, in timer units (0 = off) |
| tx_pkt_delay | input | DLY_W | Transmit packet delay, in timer units (0 = off) |
| tx_abs_delay | input | DLY_W | Transmit absolute delay, in timer units (0 = off) |
| rx_done | input | 1 | Receive descriptor completion pulse |
| tx_done | input | 1 | Transmit descriptor completion pulse |
| post_now | input | 1 | Interrupt controller is posting an interrupt now |
| rx_cause | output | 1 | One-cycle receive-timer cause pulse |
| tx_cause | output | 1 | One-cycle transmit descriptor-written cause pulse |

## Verification
The bench builds the block with DLY_W = 8 and UNIT_LOG2 = 2, so one timer unit is four clocks. With these values every expiry lands within a few dozen cycles of its completion. Restart, absolute-bound, disarm and flush cases can each be exercised in a short phase, and their expected cycles can still be worked out exactly. A unit of four also shows that the delay is scaled by the unit rather than counted in raw clocks. The scoreboard fails any cause that arrives one cycle early or one cycle late.

// File: rtl/ditmr_pkg.sv
package ditmr_pkg;

  typedef enum int unsigned {
    DIR_RX = 0,
    DIR_TX = 1
  } ditmr_dir_e;

  localparam int unsigned NUM_DIRS = 2;

endpackage

// File: rtl/ditmr_countdown.sv
// One delay timer. The delay is given in units of 2**UNIT_LOG2 clocks and
// is loaded as a single fused counter, so the expiry is exact to the cycle.
module ditmr_countdown #(
  parameter int unsigned DLY_W     = 16,
  parameter int unsigned UNIT_LOG2 = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DLY_W-1:0] dly,
  input  logic             arm,
  input  logic             kill,
  output logic             live,
  output logic             expire
);

  localparam int unsigned CNT_W = DLY_W + UNIT_LOG2;

  logic             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic             dly_on;

  assign dly_on = (dly != '0);
  assign live   = run_q && dly_on;
  assign expire = live && (cnt_q == CNT_W'(1));

  // Priority: a zero delay disarms; then a new arm; then a cancel; then count.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (!dly_on) begin
      run_q <= 1'b0;
    end else if (arm) begin
      run_q <= 1'b1;
      cnt_q <= CNT_W'(dly) << UNIT_LOG2;
    end else if (kill) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      if (cnt_q == CNT_W'(1)) begin
        run_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/ditmr_lane.sv
// One direction: a restartable packet timer plus a non-restartable
// absolute timer, merged into a single registered cause pulse.
module ditmr_lane #(
  parameter int unsigned DLY_W     = 16,
  parameter int unsigned UNIT_LOG2 = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done,
  input  logic             post_now,
  input  logic [DLY_W-1:0] pkt_dly,
  input  logic [DLY_W-1:0] abs_dly,
  output logic             cause
);

  logic pkt_on, abs_on;
  logic pkt_live, pkt_exp;
  logic abs_live, abs_exp;
  logic flush, fire;
  logic arm_pkt, arm_abs;
  logic cause_q;

  assign pkt_on = (pkt_dly != '0);
  assign abs_on = (abs_dly != '0);

  assign flush = post_now && (pkt_live || abs_live);
  assign fire  = pkt_exp || abs_exp || flush || (done && !pkt_on);

  assign arm_pkt = done && pkt_on;
  assign arm_abs = done && pkt_on && abs_on && (!abs_live || fire);

  ditmr_countdown #(
    .DLY_W     (DLY_W),
    .UNIT_LOG2 (UNIT_LOG2)
  ) u_pkt (
    .clk    (clk),
    .rst_n  (rst_n),
    .dly    (pkt_dly),
    .arm    (arm_pkt),
    .kill   (fire),
    .live   (pkt_live),
    .expire (pkt_exp)
  );

  ditmr_countdown #(
    .DLY_W     (DLY_W),
    .UNIT_LOG2 (UNIT_LOG2)
  ) u_abs (
    .clk    (clk),
    .rst_n  (rst_n),
    .dly    (abs_dly),
    .arm    (arm_abs),
    .kill   (fire),
    .live   (abs_live),
    .expire (abs_exp)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_q <= 1'b0;
    end else begin
      cause_q <= fire;
    end
  end

  assign cause = cause_q;

endmodule

// File: rtl/ditmr_top.sv
module ditmr_top #(
  parameter int unsigned DLY_W     = 16,
  parameter int unsigned UNIT_LOG2 = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DLY_W-1:0] rx_pkt_delay,
  input  logic [DLY_W-1:0] rx_abs_delay,
  input  logic [DLY_W-1:0] tx_pkt_delay,
  input  logic [DLY_W-1:0] tx_abs_delay,
  input  logic             rx_done,
  input  logic             tx_done,
  input  logic             post_now,
  output logic             rx_cause,
  output logic             tx_cause
);

  import ditmr_pkg::*;

  logic [DLY_W-1:0] pkt_v   [NUM_DIRS];
  logic [DLY_W-1:0] abs_v   [NUM_DIRS];
  logic             done_v  [NUM_DIRS];
  logic             cause_v [NUM_DIRS];

  assign pkt_v[DIR_RX]  = rx_pkt_delay;
  assign pkt_v[DIR_TX]  = tx_pkt_delay;
  assign abs_v[DIR_RX]  = rx_abs_delay;
  assign abs_v[DIR_TX]  = tx_abs_delay;
  assign done_v[DIR_RX] = rx_done;
  assign done_v[DIR_TX] = tx_done;

  for (genvar g = 0; g < NUM_DIRS; g++) begin : g_lane
    ditmr_lane #(
      .DLY_W     (DLY_W),
      .UNIT_LOG2 (UNIT_LOG2)
    ) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .done     (done_v[g]),
      .post_now (post_now),
      .pkt_dly  (pkt_v[g]),
      .abs_dly  (abs_v[g]),
      .cause    (cause_v[g])
    );
  end

  assign rx_cause = cause_v[DIR_RX];
  assign tx_cause = cause_v[DIR_TX];

endmodule

// File: rtl/ditmr_checker.sv
module ditmr_checker #(
  parameter int unsigned DLY_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DLY_W-1:0] rx_pkt_delay,
  input logic [DLY_W-1:0] rx_abs_delay,
  input logic [DLY_W-1:0] tx_pkt_delay,
  input logic [DLY_W-1:0] tx_abs_delay,
  input logic             rx_done,
  input logic             tx_done,
  input logic             post_now,
  input logic             rx_cause,
  input logic             tx_cause
);

  logic rx_seen, tx_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_seen <= 1'b0;
      tx_seen <= 1'b0;
    end else begin
      if (rx_done) rx_seen <= 1'b1;
      if (tx_done) tx_seen <= 1'b1;
    end
  end

  AST_RX_CAUSE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cause |-> rx_seen); // R1
  AST_TX_CAUSE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cause |-> tx_seen); // R1
  AST_RX_ZERO_DLY_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_pkt_delay == '0) |=> rx_cause); // R6
  AST_TX_ZERO_DLY_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && tx_pkt_delay == '0) |=> tx_cause); // R11
  AST_RX_DISARMED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_done && rx_pkt_delay == '0 && rx_abs_delay == '0) |=> !rx_cause); // R7
  AST_TX_DISARMED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_done && tx_pkt_delay == '0 && tx_abs_delay == '0) |=> !tx_cause); // R11

endmodule

bind ditmr_top ditmr_checker #(.DLY_W(DLY_W)) u_ditmr_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .rx_pkt_delay (rx_pkt_delay),
  .rx_abs_delay (rx_abs_delay),
  .tx_pkt_delay (tx_pkt_delay),
  .tx_abs_delay (tx_abs_delay),
  .rx_done      (rx_done),
  .tx_done      (tx_done),
  .post_now     (post_now),
  .rx_cause     (rx_cause),
  .tx_cause     (tx_cause)
);

// File: tb/test_ditmr_top.sv
module test_ditmr_top;

  localparam int unsigned DW   = 8;
  localparam int unsigned UL   = 2;
  localparam int          UNIT = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] rx_pkt_delay = '0, rx_abs_delay = '0;
  logic [DW-1:0] tx_pkt_delay = '0, tx_abs_delay = '0;
  logic          rx_done = 1'b0, tx_done = 1'b0, post_now = 1'b0;
  logic          rx_cause, tx_cause;

  always #5 clk = ~clk;

  ditmr_top #(.DLY_W(DW), .UNIT_LOG2(UL)) i_ditmr_top (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_pkt_delay (rx_pkt_delay),
    .rx_abs_delay (rx_abs_delay),
    .tx_pkt_delay (tx_pkt_delay),
    .tx_abs_delay (tx_abs_delay),
    .rx_done      (rx_done),
    .tx_done      (tx_done),
    .post_now     (post_now),
    .rx_cause     (rx_cause),
    .tx_cause     (tx_cause)
  );

  int    cyc = 0;
  int    n_chk = 0;
  int    n_fail = 0;
  int    rxq[$];
  int    txq[$];
  string cur_req = "R1";

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Monitor: every cause pulse must match the next expected cycle.
  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_cause) begin
        if (rxq.size() == 0) check(1'b0, {cur_req, " unexpected rx cause"}, cyc, -1);
        else begin
          check(cyc == rxq[0], {cur_req, " rx cause cycle"}, cyc, rxq[0]);
          void'(rxq.pop_front());
        end
      end
      if (tx_cause) begin
        if (txq.size() == 0) check(1'b0, {cur_req, " unexpected tx cause"}, cyc, -1);
        else begin
          check(cyc == txq[0], {cur_req, " tx cause cycle"}, cyc, txq[0]);
          void'(txq.pop_front());
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Pulse tasks start and end at a falling edge; the pulse is sampled at the
  // rising edge that makes cyc = (cyc at call) + 1.
  task automatic pulse(input bit rx, input bit tx, input bit post);
    rx_done  = rx;
    tx_done  = tx;
    post_now = post;
    @(negedge clk);
    rx_done  = 1'b0;
    tx_done  = 1'b0;
    post_now = 1'b0;
  endtask

  task automatic drain(input string req);
    check(rxq.size() == 0 && txq.size() == 0, {req, " pending expectations"},
          rxq.size() + txq.size(), 0);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1: reset state
    check(rx_cause == 1'b0, "R1 rx_cause after reset", int'(rx_cause), 0);
    check(tx_cause == 1'b0, "R1 tx_cause after reset", int'(tx_cause), 0);
    idle(5);

    // R2: single completion, packet timer only
    cur_req = "R2";
    rx_pkt_delay = 8'd5;
    rxq.push_back(cyc + 1 + 5 * UNIT);
    pulse(1, 0, 0);
    idle(30);
    drain("R2");

    // R3: second completion restarts the packet timer
    cur_req = "R3";
    pulse(1, 0, 0);
    idle(11);
    rxq.push_back(cyc + 1 + 5 * UNIT);
    pulse(1, 0, 0);
    idle(30);
    drain("R3");

    // R4 R10: absolute timer bounds the wait and cancels the packet timer
    cur_req = "R4";
    rx_abs_delay = 8'd8;
    rxq.push_back(cyc + 1 + 8 * UNIT);
    pulse(1, 0, 0);
    idle(9);
    pulse(1, 0, 0);
    idle(9);
    pulse(1, 0, 0);
    idle(30);
    drain("R4 R10");

    // R5 R6: zero packet delay fires at once and leaves absolute unarmed
    cur_req = "R6";
    rx_pkt_delay = 8'd0;
    rxq.push_back(cyc + 1);
    pulse(1, 0, 0);
    idle(40);
    drain("R5");

    // R7: zeroing the packet delay disarms it for good
    cur_req = "R7";
    rx_abs_delay = 8'd0;
    rx_pkt_delay = 8'd5;
    pulse(1, 0, 0);
    idle(4);
    rx_pkt_delay = 8'd0;
    idle(2);
    rx_pkt_delay = 8'd5;
    idle(30);
    drain("R7 packet");

    // R7: zeroing the absolute delay disarms only the absolute timer
    rx_abs_delay = 8'd3;
    rxq.push_back(cyc + 1 + 5 * UNIT);
    pulse(1, 0, 0);
    idle(3);
    rx_abs_delay = 8'd0;
    idle(2);
    rx_abs_delay = 8'd3;
    idle(25);
    drain("R7 absolute");

    // R8: post_now flushes pending timers
    cur_req = "R8";
    rx_abs_delay = 8'd8;
    pulse(1, 0, 0);
    idle(5);
    rxq.push_back(cyc + 1);
    pulse(0, 0, 1);
    idle(40);
    drain("R8");

    // R9: post_now with nothing pending
    cur_req = "R9";
    pulse(0, 0, 1);
    idle(10);
    drain("R9");

    // R11: transmit direction, independent of receive
    cur_req = "R11";
    rx_abs_delay = 8'd0;
    tx_pkt_delay = 8'd3;
    rxq.push_back(cyc + 1 + 5 * UNIT);
    txq.push_back(cyc + 1 + 3 * UNIT);
    pulse(1, 1, 0);
    idle(30);
    drain("R11 both");
    tx_pkt_delay = 8'd5;
    tx_abs_delay = 8'd4;
    txq.push_back(cyc + 1 + 4 * UNIT);
    pulse(0, 1, 0);
    idle(7);
    pulse(0, 1, 0);
    idle(30);
    drain("R11 absolute");
    tx_pkt_delay = 8'd0;
    tx_abs_delay = 8'd0;
    txq.push_back(cyc + 1);
    pulse(0, 1, 0);
    idle(5);
    drain("R11 zero delay");

    // R12: completion in the same cycle as a flush re-arms
    cur_req = "R12";
    pulse(1, 0, 0);
    idle(5);
    rxq.push_back(cyc + 1);
    rxq.push_back(cyc + 1 + 5 * UNIT);
    pulse(1, 0, 1);
    idle(30);
    drain("R12");

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule